// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns four raw external interrupt request pins into four clean pending-interrupt indications for a downstream interrupt controller. Each pin crosses into the clock domain through a two-flop synchronizer. After that it is interpreted in one of four sense modes chosen per pin: active-high level, active-low level, rising edge or falling edge.

In the level modes the pending output follows the synchronized pin, adjusted for polarity. In the edge modes a qualifying edge sets a sticky pending flag. The flag stays set until software writes a one to that pin's write-one-to-clear bit.

A single master enable masks every pending output and blocks new edges from being captured. All configuration sits in one 32-bit control word, written through a simple write strobe and read back at all times. Software clears a serviced edge interrupt by rewriting the control word with the pin's clear bit set. The word it writes also carries the unchanged configuration.

Top module: `ext_irq_cond`

## Requirements
- R1: Each input i (0..3) has a 2-bit sense field at control-word bits [23-2i:22-2i] (LSB-0 numbering). The codes are 00 = level active high, 01 = rising edge, 10 = falling edge, 11 = level active low.
- R2: A read returns the four sense fields and the master enable (bit 12) exactly as last written. Every other bit, including the clear bits, reads as 0, and writes to those other bits have no lasting effect.
- R3: In a level mode the pending output of the input equals the pin level two clocks earlier, XORed with 1 for the active-low code. The output is not latched.
- R4: In an edge mode a qualifying edge of the synchronized pin sets the pending output. The output then stays set while the pin keeps changing.
- R5: Writing 1 to control bit 27-i clears the edge pending flag of input i. Writing 0 to that bit leaves the flag unchanged, and in level modes the clear bit has no effect on the output.
- R6: While the master enable (bit 12) is 0, all pending outputs are 0 and edges that occur are not captured, so they do not appear once the enable is set again.
- R7: After reset the control word reads 0, every input is in active-high level mode, the master enable is off and all pending outputs are 0.
- R8: If a qualifying edge is detected in the same cycle as a clear write for that input, the pending flag stays set.
- R9: A write that changes an input's sense field clears that input's edge pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word read data |
| irq_pin | input | 4 | Raw external interrupt request pins, bit i is input i |
| irq_pend | output | 4 | Pending indications, bit i is input i |

## Verification
The bench goes after the cases where the sticky flag can go wrong. These are a clear write that lands in the same cycle as a fresh edge, which a design that gives the clear priority would lose, and a sense-field change, which a design without the reconfiguration wipe would follow with a stale flag. It also toggles pins while the master enable is off, which catches a design that captures edges while masked or lets its edge history go stale so that a phantom edge appears when the enable returns. Clear writes in level mode and clear writes of zero confirm that clears touch only edge state, and a full-ones write checks that clear and reserved bits read back as zero.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned IRQ_COUNT   = 4;
  localparam int unsigned CTRL_W      = 32;
  localparam int unsigned SENSE_W     = 2;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned MEN_BIT     = 12;
  localparam int unsigned CLR_TOP     = 27;
  localparam int unsigned SENSE_TOP   = 23;

  localparam logic [SENSE_W-1:0] SENSE_LVL_HI = 2'b00;
  localparam logic [SENSE_W-1:0] SENSE_RISE   = 2'b01;
  localparam logic [SENSE_W-1:0] SENSE_FALL   = 2'b10;
  localparam logic [SENSE_W-1:0] SENSE_LVL_LO = 2'b11;

  function automatic int unsigned clr_bit(input int unsigned idx);
    return CLR_TOP - idx;
  endfunction

  function automatic int unsigned sense_lsb(input int unsigned idx);
    return SENSE_TOP - 1 - SENSE_W * idx;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int s = 1; s < int'(STAGES); s++) stage_d[s] = stage_q[s-1];
  end

  generate
    for (genvar s = 0; s < int'(STAGES); s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import ext_irq_pkg::*;
#(
  parameter int unsigned N = IRQ_COUNT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [CTRL_W-1:0]         wdata,
  output logic [CTRL_W-1:0]         rdata,
  output logic [N-1:0][SENSE_W-1:0] sense_o,
  output logic                      men_o,
  output logic [N-1:0]              clr_o,
  output logic [N-1:0]              chg_o
);
  logic [N-1:0][SENSE_W-1:0] sense_q, sense_d;
  logic                      men_q, men_d;

  always_comb begin
    sense_d = sense_q;
    men_d   = men_q;
    if (wr_en) begin
      men_d = wdata[MEN_BIT];
      for (int i = 0; i < int'(N); i++) sense_d[i] = wdata[sense_lsb(i) +: SENSE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      men_q   <= 1'b0;
    end else begin
      sense_q <= sense_d;
      men_q   <= men_d;
    end
  end

  always_comb begin
    rdata          = '0;
    rdata[MEN_BIT] = men_q;
    for (int i = 0; i < int'(N); i++) begin
      rdata[sense_lsb(i) +: SENSE_W] = sense_q[i];
      clr_o[i] = wr_en & wdata[clr_bit(i)];
      chg_o[i] = wr_en & (wdata[sense_lsb(i) +: SENSE_W] != sense_q[i]);
    end
  end

  assign sense_o = sense_q;
  assign men_o   = men_q;

  // R2: the enable written is the enable held
  a_r2_enable_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (men_o == $past(wdata[MEN_BIT])));
endmodule

// File: rtl/irq_sense_chan.sv
module irq_sense_chan
  import ext_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_s,
  input  logic [SENSE_W-1:0] sense,
  input  logic               men,
  input  logic               clr,
  input  logic               chg,
  output logic               pend
);
  logic prev_q, prev_d;
  logic flag_q, flag_d;
  logic edge_evt;
  logic level_mode;

  assign level_mode = (sense == SENSE_LVL_HI) || (sense == SENSE_LVL_LO);

  always_comb begin
    unique case (sense)
      SENSE_RISE: edge_evt = pin_s & ~prev_q;
      SENSE_FALL: edge_evt = ~pin_s & prev_q;
      default:    edge_evt = 1'b0;
    endcase
  end

  always_comb begin
    prev_d = pin_s;
    flag_d = flag_q;
    if (chg)                  flag_d = 1'b0;
    else if (men && edge_evt) flag_d = 1'b1;
    else if (clr)             flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    if (!men)            pend = 1'b0;
    else if (level_mode) pend = pin_s ^ (sense == SENSE_LVL_LO);
    else                 pend = flag_q;
  end

  // R4: a captured edge persists until cleared or reconfigured
  a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr && !chg) |=> flag_q);
  // R5: a clear without a coincident edge drops the flag
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !chg && !(men && edge_evt)) |=> !flag_q);
  // R8: a new edge beats a coincident clear
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (men && edge_evt && clr && !chg) |=> flag_q);
  // R9: reconfiguration wipes the flag
  a_r9_reconfig_clears: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !flag_q);
  // R6: no capture while masked
  a_r6_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!men && !flag_q) |=> !flag_q);
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic [IRQ_COUNT-1:0] irq_pin,
  output logic [IRQ_COUNT-1:0] irq_pend
);
  logic [1:0] rst_q, rst_d;
  logic       rst_int_n;

  assign rst_d = {rst_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= rst_d;
  end

  assign rst_int_n = rst_q[1];

  logic [IRQ_COUNT-1:0]              pin_s;
  logic [IRQ_COUNT-1:0][SENSE_W-1:0] sense;
  logic                              men;
  logic [IRQ_COUNT-1:0]              clr;
  logic [IRQ_COUNT-1:0]              chg;

  irq_sync #(.WIDTH(IRQ_COUNT), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (irq_pin),
    .q    (pin_s)
  );

  irq_ctrl_reg #(.N(IRQ_COUNT)) reg_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (ctrl_wr),
    .wdata  (ctrl_wdata),
    .rdata  (ctrl_rdata),
    .sense_o(sense),
    .men_o  (men),
    .clr_o  (clr),
    .chg_o  (chg)
  );

  generate
    for (genvar i = 0; i < int'(IRQ_COUNT); i++) begin : g_chan
      irq_sense_chan chan_i (
        .clk  (clk),
        .rst_n(rst_int_n),
        .pin_s(pin_s[i]),
        .sense(sense[i]),
        .men  (men),
        .clr  (clr[i]),
        .chg  (chg[i]),
        .pend (irq_pend[i])
      );
    end
  endgenerate

  // R6: masked block shows no pending interrupt one cycle after disable
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctrl_wr && !ctrl_wdata[MEN_BIT]) |=> (irq_pend == '0));
endmodule

// File: tb/ext_irq_cond_tb_top.sv
module ext_irq_cond_tb_top;
  logic        clk;
  logic        rst_n;
  logic        ctrl_wr;
  logic [31:0] ctrl_wdata;
  logic [31:0] ctrl_rdata;
  logic [3:0]  irq_pin;
  logic [3:0]  irq_pend;

  int n_cmp;
  int n_bad;
  bit done;

  ext_irq_cond dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata),
    .irq_pin   (irq_pin),
    .irq_pend  (irq_pend)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [31:0] wdata;
    logic [3:0]  pin;
    logic [3:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  // sense fields: IRQ0 [23:22], IRQ1 [21:20], IRQ2 [19:18], IRQ3 [17:16]; enable bit 12; clear bits 27..24
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_1000, 4'b0000, 4'b0000, 4'd3},  // R3 enable, all level high, pins low
    '{1'b0, 32'h0,         4'b0101, 4'b0101, 4'd3},  // R3 level high follows pins
    '{1'b1, 32'h0F00_1000, 4'b0101, 4'b0101, 4'd5},  // R5 clear bits ignored in level mode
    '{1'b1, 32'h006C_1000, 4'b0000, 4'b0100, 4'd1},  // R1 rise/fall/low/high mix
    '{1'b0, 32'h0,         4'b0011, 4'b0101, 4'd4},  // R4 irq0 rise captured
    '{1'b0, 32'h0,         4'b0000, 4'b0111, 4'd4},  // R4 irq0 holds, irq1 fall captured
    '{1'b1, 32'h086C_1000, 4'b0000, 4'b0110, 4'd5},  // R5 clear irq0
    '{1'b1, 32'h006C_1000, 4'b0000, 4'b0110, 4'd5},  // R5 clear bit 0 does nothing
    '{1'b1, 32'h046C_1000, 4'b0000, 4'b0100, 4'd5},  // R5 clear irq1
    '{1'b1, 32'h006C_0000, 4'b0000, 4'b0000, 4'd6},  // R6 disable masks all
    '{1'b0, 32'h0,         4'b0001, 4'b0000, 4'd6},  // R6 edge while disabled
    '{1'b1, 32'h006C_1000, 4'b0001, 4'b0100, 4'd6},  // R6 masked edge not captured
    '{1'b0, 32'h0,         4'b0100, 4'b0000, 4'd3},  // R3 active low deasserts
    '{1'b0, 32'h0,         4'b0101, 4'b0001, 4'd4},  // R4 rise captured
    '{1'b1, 32'h00AC_1000, 4'b0101, 4'b0000, 4'd9},  // R9 sense change wipes flag
    '{1'b0, 32'h0,         4'b0100, 4'b0001, 4'd1}   // R1 falling code on irq0
  };

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] w);
    ctrl_wr    = 1'b1;
    ctrl_wdata = w;
    tick(1);
    ctrl_wr    = 1'b0;
    ctrl_wdata = '0;
  endtask

  initial begin
    ctrl_wr = 1'b0; ctrl_wdata = '0; irq_pin = '0; rst_n = 1'b0;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R7 reset state
    chk(ctrl_rdata, 32'h0, "R7 rdata");
    irq_pin = 4'b1111;
    tick(4);
    chk({28'h0, irq_pend}, 32'h0, "R7 pend with enable off");
    irq_pin = 4'b0000;
    tick(4);

    for (int v = 0; v < NV; v++) begin
      ctrl_wr    = VECS[v].wr;
      ctrl_wdata = VECS[v].wdata;
      irq_pin    = VECS[v].pin;
      tick(1);
      ctrl_wr    = 1'b0;
      ctrl_wdata = '0;
      tick(4);
      n_cmp++;
      if (irq_pend !== VECS[v].exp) begin
        n_bad++;
        $display("FAIL R%0d vector %0d actual=%b expected=%b", VECS[v].req, v, irq_pend, VECS[v].exp);
      end
    end

    // R2 readback drops clear and reserved bits
    wr_word(32'hFFFF_FFFF);
    chk(ctrl_rdata, 32'h00FF_1000, "R2 readback");
    wr_word(32'h0000_0000);
    chk(ctrl_rdata, 32'h0, "R2 readback zero");

    // R8 edge coinciding with clear: irq0 rising, enabled
    irq_pin = 4'b0000;
    wr_word(32'h0040_1000);
    tick(4);
    irq_pin = 4'b0001;
    tick(5);
    chk({28'h0, irq_pend}, 32'h1, "R4 rise set");
    irq_pin = 4'b0000;
    tick(5);
    irq_pin = 4'b0001;        // reaches edge detection two edges later
    tick(2);
    wr_word(32'h0840_1000);   // clear sampled at the edge where the new edge is seen
    tick(3);
    chk({28'h0, irq_pend}, 32'h1, "R8 edge beats clear");
    wr_word(32'h0840_1000);
    tick(2);
    chk({28'h0, irq_pend}, 32'h0, "R5 plain clear");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule